// File: doc/BRIEF.md
# Dual-Issue Pairing and Interlock Stage

This block makes the issue decision for a two-wide, strictly in-order pipeline. In each cycle it looks at the two oldest decoded micro-operations from the upstream queue. The head entry is the older slot and the entry behind it is the younger slot. The block then chooses one of three outcomes: both operations leave together, only the older one leaves, or nothing leaves. If the younger operation is interlocked, it is not lost. The upstream queue advances only by the consumed count, so that operation moves into the older slot in the next cycle and is considered again there.

The upstream side behaves like a valid/ready stream. Each slot has its own valid bit, and `consumed` acts as the ready signal for the two entries. A slot counts as accepted only when it is counted in `consumed`. The older slot is always counted before the younger one, and a younger valid is only meaningful while the older slot is also valid. On the downstream side, one registered lane per execution way carries each issued descriptor and its valid bit. `stall` is the back-pressure from the execution side. While it is high, nothing is accepted and both lanes keep their contents.

Pairing is refused for four reasons: a register dependency between the two operations; two operations that need the same single-instance resource; an operation that must always travel alone; and a memory access that crosses the boundary its kind cannot straddle. Loads may not cross a 32-bit boundary and stores may not cross a 64-bit boundary.

Top module: `dual_issue_pair`

## Requirements
- R1: When `stall` is low and reset is released, `issue_older` equals `older_valid`. `consumed` always equals the number of slots issued in that cycle, as 0, 1 or 2.
- R2: `issue_younger` is high only together with `issue_older`. It requires both valid bits, and it is high exactly when none of the rules in R3, R4, R5, R6, R7 and R8 applies.
- R3: The younger operation is held when the older operation has its destination enable set and the older destination equals either younger source or, if the younger destination enable is set, the younger destination. Sources are always compared.
- R4: Operation classes are coded ALU=0, SIMD=1, LOAD=2, STORE=3, FPU=4, FP-long=5, integer divide=6, MAC=7. Two SIMD operations do not pair, because only one ALU runs SIMD. Two FPU operations do not pair, because there is one floating-point way. An FPU operation next to any integer class does pair.
- R5: A class 5 operation (FP divide, square root or double precision) or a class 6 operation (integer divide) never pairs, whichever slot it occupies.
- R6: A LOAD with size code s transfers 2^s bytes. Its 3-bit offset `a` makes it cross a 32-bit boundary when (a mod 4) + 2^s > 4. Such a load never pairs, in either slot.
- R7: A STORE with size code s and 3-bit offset `a` crosses a 64-bit boundary when a + 2^s > 8. Such a store never pairs, in either slot.
- R8: An operation with its special flag set never pairs, in either slot. The special flag marks supervisor calls, breakpoints, special-register moves and barriers.
- R9: While `stall` is high, `issue_older`, `issue_younger` and `consumed` are all zero. Both lanes keep their valid bits and descriptors unchanged.
- R10: On every clock edge where `stall` is low, lane 0 takes `issue_older` and the older descriptor, and lane 1 takes `issue_younger` and the younger descriptor.
- R11: While `rst_n` is low, nothing issues, and after a clock edge both lane valid bits are zero.
- R12: A queue that advances by `consumed` delivers every operation to the lanes exactly once and in program order, even under arbitrary stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears the lanes and blocks issue |
| stall | input | 1 | Execution side busy; back-pressure for both lanes |
| older_valid | input | 1 | Older slot holds an operation |
| older_uop | input | UOP_W (22) | Older descriptor, layout `dii_pkg::uop_t` |
| younger_valid | input | 1 | Younger slot holds an operation |
| younger_uop | input | UOP_W (22) | Younger descriptor, layout `dii_pkg::uop_t` |
| issue_older | output | 1 | Older slot issues this cycle |
| issue_younger | output | 1 | Younger slot issues alongside the older one |
| consumed | output | 2 | Number of slots accepted this cycle |
| lane0_valid | output | 1 | Lane 0 holds an issued operation |
| lane0_uop | output | UOP_W (22) | Lane 0 descriptor |
| lane1_valid | output | 1 | Lane 1 holds an issued operation |
| lane1_uop | output | UOP_W (22) | Lane 1 descriptor |

## Verification
The assertions assume that the upstream queue never marks the younger slot valid while the older slot is empty. Without that guarantee, program order at the block's inputs would already be broken. The assertions also assume that descriptors are stable from one edge to the next, and that reset is driven low from time zero. The stimulus respects these conditions. Every directed sweep pairs a younger valid with an older valid. The queue replay fills the younger slot only when an entry exists behind the head. All inputs change on the falling edge, half a period away from the edge at which the lanes capture.

// File: rtl/dii_pkg.sv
`timescale 1ns/1ps
package dii_pkg;
  localparam int REG_W      = 4;
  localparam int OFS_W      = 3;
  localparam int SIZE_W     = 2;
  localparam int LANES      = 2;
  localparam int WORD_BYTES = 4;
  localparam int DWORD_BYTES = 8;
  localparam int SPAN_W     = OFS_W + 2;

  typedef enum logic [2:0] {
    CLS_ALU    = 3'd0,
    CLS_SIMD   = 3'd1,
    CLS_LOAD   = 3'd2,
    CLS_STORE  = 3'd3,
    CLS_FPU    = 3'd4,
    CLS_FPLONG = 3'd5,
    CLS_IDIV   = 3'd6,
    CLS_MAC    = 3'd7
  } op_cls_e;

  typedef struct packed {
    logic              special;
    op_cls_e           cls;
    logic [SIZE_W-1:0] size;
    logic [OFS_W-1:0]  ofs;
    logic              dst_en;
    logic [REG_W-1:0]  dst;
    logic [REG_W-1:0]  src_a;
    logic [REG_W-1:0]  src_b;
  } uop_t;

  localparam int UOP_W = $bits(uop_t);
endpackage

// File: rtl/dii_solo_check.sv
`timescale 1ns/1ps
module dii_solo_check
  import dii_pkg::*;
(
  input  uop_t op,
  output logic solo
);
  logic [SPAN_W-1:0] nbytes;
  logic [SPAN_W-1:0] word_end;
  logic [SPAN_W-1:0] dword_end;
  logic              load_split;
  logic              store_split;
  logic              long_op;

  always_comb begin
    nbytes      = SPAN_W'(1) << op.size;
    word_end    = SPAN_W'(op.ofs[1:0]) + nbytes;
    dword_end   = SPAN_W'(op.ofs) + nbytes;
    load_split  = (op.cls == CLS_LOAD)  && (word_end  > SPAN_W'(WORD_BYTES));
    store_split = (op.cls == CLS_STORE) && (dword_end > SPAN_W'(DWORD_BYTES));
    long_op     = (op.cls == CLS_FPLONG) || (op.cls == CLS_IDIV);
    solo        = op.special | long_op | load_split | store_split;
  end
endmodule

// File: rtl/dii_pair_hazard.sv
`timescale 1ns/1ps
module dii_pair_hazard
  import dii_pkg::*;
(
  input  uop_t older,
  input  uop_t younger,
  output logic dep,
  output logic clash
);
  logic hit_a, hit_b, hit_d;

  always_comb begin
    hit_a = (younger.src_a == older.dst);
    hit_b = (younger.src_b == older.dst);
    hit_d = younger.dst_en && (younger.dst == older.dst);
    dep   = older.dst_en && (hit_a || hit_b || hit_d);
    clash = ((older.cls == CLS_SIMD) && (younger.cls == CLS_SIMD)) ||
            ((older.cls == CLS_FPU)  && (younger.cls == CLS_FPU));
  end
endmodule

// File: rtl/dii_issue_lanes.sv
`timescale 1ns/1ps
module dii_issue_lanes #(
  parameter int W = 8,
  parameter int N = 2
)(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hold,
  input  logic [N-1:0]        in_valid,
  input  logic [N-1:0][W-1:0] in_data,
  output logic [N-1:0]        out_valid,
  output logic [N-1:0][W-1:0] out_data
);
  for (genvar g = 0; g < N; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        out_valid[g] <= 1'b0;
        out_data[g]  <= '0;
      end else if (!hold) begin
        out_valid[g] <= in_valid[g];
        out_data[g]  <= in_data[g];
      end
    end
  end
endmodule

// File: rtl/dual_issue_pair.sv
`timescale 1ns/1ps
module dual_issue_pair
  import dii_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stall,
  input  logic             older_valid,
  input  logic [UOP_W-1:0] older_uop,
  input  logic             younger_valid,
  input  logic [UOP_W-1:0] younger_uop,
  output logic             issue_older,
  output logic             issue_younger,
  output logic [1:0]       consumed,
  output logic             lane0_valid,
  output logic [UOP_W-1:0] lane0_uop,
  output logic             lane1_valid,
  output logic [UOP_W-1:0] lane1_uop
);
  uop_t slot_uop [LANES];
  logic [LANES-1:0] solo;
  logic dep, clash, go, pair_ok;

  assign slot_uop[0] = uop_t'(older_uop);
  assign slot_uop[1] = uop_t'(younger_uop);

  for (genvar g = 0; g < LANES; g++) begin : g_solo
    dii_solo_check u_solo (
      .op   (slot_uop[g]),
      .solo (solo[g])
    );
  end

  dii_pair_hazard u_haz (
    .older   (slot_uop[0]),
    .younger (slot_uop[1]),
    .dep     (dep),
    .clash   (clash)
  );

  always_comb begin
    go            = rst_n && !stall;
    pair_ok       = older_valid && younger_valid && !(|solo) && !dep && !clash;
    issue_older   = go && older_valid;
    issue_younger = go && pair_ok;
    consumed      = 2'(issue_older) + 2'(issue_younger);
  end

  logic [LANES-1:0]            lane_v_in, lane_v_out;
  logic [LANES-1:0][UOP_W-1:0] lane_d_in, lane_d_out;

  assign lane_v_in = {issue_younger, issue_older};
  assign lane_d_in = {younger_uop, older_uop};

  dii_issue_lanes #(.W(UOP_W), .N(LANES)) u_lanes (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold      (stall),
    .in_valid  (lane_v_in),
    .in_data   (lane_d_in),
    .out_valid (lane_v_out),
    .out_data  (lane_d_out)
  );

  assign lane0_valid = lane_v_out[0];
  assign lane1_valid = lane_v_out[1];
  assign lane0_uop   = lane_d_out[0];
  assign lane1_uop   = lane_d_out[1];
endmodule

// File: rtl/dual_issue_pair_chk.sv
`timescale 1ns/1ps
module dual_issue_pair_chk
  import dii_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             stall,
  input logic             older_valid,
  input logic [UOP_W-1:0] older_uop,
  input logic             younger_valid,
  input logic [UOP_W-1:0] younger_uop,
  input logic             issue_older,
  input logic             issue_younger,
  input logic [1:0]       consumed,
  input logic             lane0_valid,
  input logic [UOP_W-1:0] lane0_uop,
  input logic             lane1_valid,
  input logic [UOP_W-1:0] lane1_uop
);
  uop_t o_u, y_u;
  logic y_load_split, y_store_split, long_any, raw_hit;

  always_comb begin
    o_u = uop_t'(older_uop);
    y_u = uop_t'(younger_uop);
    y_load_split  = (y_u.cls == CLS_LOAD) &&
                    ((int'(y_u.ofs) % 4) + (1 << int'(y_u.size)) > 4);
    y_store_split = (y_u.cls == CLS_STORE) &&
                    (int'(y_u.ofs) + (1 << int'(y_u.size)) > 8);
    long_any = (o_u.cls inside {CLS_FPLONG, CLS_IDIV}) ||
               (y_u.cls inside {CLS_FPLONG, CLS_IDIV});
    raw_hit  = o_u.dst_en && ((y_u.src_a == o_u.dst) || (y_u.src_b == o_u.dst));
  end

  AST_OLDER_GOES: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && older_valid) |-> issue_older); // R1
  AST_YOUNGER_WITH_OLDER: assert property (@(posedge clk) disable iff (!rst_n)
    issue_younger |-> (issue_older && consumed == 2'd2)); // R2
  AST_RAW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    raw_hit |-> !issue_younger); // R3
  AST_SIMD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (o_u.cls == CLS_SIMD && y_u.cls == CLS_SIMD) |-> !issue_younger); // R4
  AST_LONG_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    long_any |-> !issue_younger); // R5
  AST_LOAD_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    y_load_split |-> !issue_younger); // R6
  AST_STORE_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    y_store_split |-> !issue_younger); // R7
  AST_SPECIAL_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    (o_u.special || y_u.special) |-> !issue_younger); // R8
  AST_STALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (!issue_older && !issue_younger && consumed == 2'd0)); // R9
  AST_LANE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($stable(lane0_valid) && $stable(lane1_valid) &&
               $stable(lane0_uop) && $stable(lane1_uop))); // R9
  AST_LANE_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !stall |=> (lane0_valid == $past(issue_older) &&
                lane1_valid == $past(issue_younger))); // R10
endmodule

bind dual_issue_pair dual_issue_pair_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .stall         (stall),
  .older_valid   (older_valid),
  .older_uop     (older_uop),
  .younger_valid (younger_valid),
  .younger_uop   (younger_uop),
  .issue_older   (issue_older),
  .issue_younger (issue_younger),
  .consumed      (consumed),
  .lane0_valid   (lane0_valid),
  .lane0_uop     (lane0_uop),
  .lane1_valid   (lane1_valid),
  .lane1_uop     (lane1_uop)
);

// File: tb/dual_issue_pair_bench.sv
`timescale 1ns/1ps
module dual_issue_pair_bench;
  import dii_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stall = 1'b0;
  logic older_valid = 1'b0, younger_valid = 1'b0;
  logic [UOP_W-1:0] older_uop = '0, younger_uop = '0;
  logic issue_older, issue_younger, lane0_valid, lane1_valid;
  logic [1:0] consumed;
  logic [UOP_W-1:0] lane0_uop, lane1_uop;

  int n_chk = 0;
  int n_bad = 0;
  localparam int QN = 48;
  uop_t q [QN];

  always #2 clk = ~clk;

  dual_issue_pair u_dual_issue_pair (
    .clk(clk), .rst_n(rst_n), .stall(stall),
    .older_valid(older_valid), .older_uop(older_uop),
    .younger_valid(younger_valid), .younger_uop(younger_uop),
    .issue_older(issue_older), .issue_younger(issue_younger),
    .consumed(consumed),
    .lane0_valid(lane0_valid), .lane0_uop(lane0_uop),
    .lane1_valid(lane1_valid), .lane1_uop(lane1_uop)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic uop_t mk(input op_cls_e c, input int d, input int sa, input int sb,
                              input bit den, input int sz, input int of, input bit sp);
    uop_t u;
    u.special = sp; u.cls = c; u.size = SIZE_W'(sz); u.ofs = OFS_W'(of);
    u.dst_en = den; u.dst = REG_W'(d); u.src_a = REG_W'(sa); u.src_b = REG_W'(sb);
    return u;
  endfunction

  function automatic bit alone(input uop_t u);
    int nb = 1 << int'(u.size);
    int a  = int'(u.ofs);
    if (u.special) return 1'b1;
    if (u.cls == CLS_FPLONG || u.cls == CLS_IDIV) return 1'b1;
    if (u.cls == CLS_LOAD && (a % 4) + nb > 4) return 1'b1;
    if (u.cls == CLS_STORE && a + nb > 8) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit pairable(input uop_t o, input uop_t y);
    bit dep = o.dst_en && (y.src_a == o.dst || y.src_b == o.dst ||
                           (y.dst_en && y.dst == o.dst));
    bit clash = (o.cls == CLS_SIMD && y.cls == CLS_SIMD) ||
                (o.cls == CLS_FPU && y.cls == CLS_FPU);
    return !(dep || clash || alone(o) || alone(y));
  endfunction

  task automatic step(input uop_t o, input bit ov, input uop_t y, input bit yv,
                      input bit st, input string req);
    logic p0v, p1v;
    logic [UOP_W-1:0] p0u, p1u;
    bit eo, ey;
    @(negedge clk);
    p0v = lane0_valid; p1v = lane1_valid; p0u = lane0_uop; p1u = lane1_uop;
    older_uop = o; older_valid = ov; younger_uop = y; younger_valid = yv; stall = st;
    #1;
    eo = ov && !st;
    ey = eo && yv && pairable(o, y);
    chk(issue_older == eo, {req, " R1 older"}, int'(issue_older), int'(eo));
    chk(issue_younger == ey, {req, " R2 younger"}, int'(issue_younger), int'(ey));
    chk(int'(consumed) == int'(eo) + int'(ey), "R1 consumed", int'(consumed), int'(eo) + int'(ey));
    @(posedge clk); #1;
    if (st) begin
      chk(lane0_valid == p0v && lane1_valid == p1v, "R9 lane valid hold",
          int'({lane1_valid, lane0_valid}), int'({p1v, p0v}));
      chk(lane0_uop == p0u && lane1_uop == p1u, "R9 lane data hold",
          int'(lane0_uop), int'(p0u));
    end else begin
      chk(lane0_valid == eo && lane1_valid == ey, "R10 lane valid",
          int'({lane1_valid, lane0_valid}), int'({ey, eo}));
      if (eo) chk(lane0_uop == o, "R10 lane0 data", int'(lane0_uop), int'(o));
      if (ey) chk(lane1_uop == y, "R10 lane1 data", int'(lane1_uop), int'(y));
    end
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    uop_t alu_a, alu_b;
    alu_a = mk(CLS_ALU, 1, 2, 3, 1'b1, 2, 0, 1'b0);
    alu_b = mk(CLS_ALU, 4, 5, 6, 1'b1, 2, 0, 1'b0);

    // R11: reset blocks issue and clears the lanes
    older_uop = alu_a; younger_uop = alu_b; older_valid = 1'b1; younger_valid = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(issue_older == 1'b0 && consumed == 2'd0, "R11 no issue in reset", int'(consumed), 0);
    chk(lane0_valid == 1'b0 && lane1_valid == 1'b0, "R11 lanes clear",
        int'({lane1_valid, lane0_valid}), 0);
    rst_n = 1'b1;

    // R1: valid patterns
    step(alu_a, 1'b0, alu_b, 1'b0, 1'b0, "R1 empty");
    step(alu_a, 1'b1, alu_b, 1'b0, 1'b0, "R1 older only");
    step(alu_a, 1'b1, alu_b, 1'b1, 1'b0, "R2 clean pair");

    // R4, R5: every class pairing, aligned words, no shared registers
    for (int co = 0; co < 8; co++)
      for (int cy = 0; cy < 8; cy++)
        step(mk(op_cls_e'(co), 1, 2, 3, 1'b1, 2, 0, 1'b0), 1'b1,
             mk(op_cls_e'(cy), 4, 5, 6, 1'b1, 2, 0, 1'b0), 1'b1, 1'b0, "R4 R5 class");

    // R6, R7: memory op of every size and offset in both slots
    for (int sl = 0; sl < 2; sl++)
      for (int k = 0; k < 2; k++)
        for (int sz = 0; sz < 4; sz++)
          for (int of = 0; of < 8; of++) begin
            uop_t m;
            m = mk(k == 0 ? CLS_LOAD : CLS_STORE, 7, 8, 9, 1'b1, sz, of, 1'b0);
            if (sl == 0) step(m, 1'b1, alu_b, 1'b1, 1'b0, k == 0 ? "R6 load" : "R7 store");
            else         step(alu_a, 1'b1, m, 1'b1, 1'b0, k == 0 ? "R6 load" : "R7 store");
          end

    // R3: register dependency sweep
    for (int od = 0; od < 4; od++)
      for (int oe = 0; oe < 2; oe++)
        for (int sa = 0; sa < 4; sa++)
          for (int sb = 0; sb < 4; sb++)
            for (int yd = 0; yd < 4; yd++)
              for (int ye = 0; ye < 2; ye++)
                step(mk(CLS_ALU, od, 8, 9, oe[0], 2, 0, 1'b0), 1'b1,
                     mk(CLS_MAC, yd, sa, sb, ye[0], 2, 0, 1'b0), 1'b1, 1'b0, "R3 dep");

    // R8: special flag in either slot
    for (int m = 1; m < 4; m++)
      step(mk(CLS_ALU, 1, 2, 3, 1'b1, 2, 0, m[0]), 1'b1,
           mk(CLS_ALU, 4, 5, 6, 1'b1, 2, 0, m[1]), 1'b1, 1'b0, "R8 special");

    // R9: stall with lanes loaded, then with other content presented
    step(alu_a, 1'b1, alu_b, 1'b1, 1'b0, "R9 preload");
    step(alu_b, 1'b1, alu_a, 1'b1, 1'b1, "R9 stall pair");
    step(mk(CLS_IDIV, 3, 0, 0, 1'b1, 2, 0, 1'b0), 1'b1, alu_b, 1'b1, 1'b1, "R9 stall solo");
    step(alu_b, 1'b1, alu_a, 1'b0, 1'b0, "R10 after stall");

    // R11: reset mid-run clears loaded lanes
    step(alu_a, 1'b1, alu_b, 1'b1, 1'b0, "R11 preload");
    @(negedge clk); rst_n = 1'b0;
    #1 chk(issue_older == 1'b0, "R11 issue gated", int'(issue_older), 0);
    @(posedge clk); #1;
    chk(lane0_valid == 1'b0 && lane1_valid == 1'b0, "R11 lanes cleared",
        int'({lane1_valid, lane0_valid}), 0);
    @(negedge clk); rst_n = 1'b1;

    // R12: queue replay with pseudo-random stalls
    for (int i = 0; i < QN; i++)
      q[i] = mk(op_cls_e'(i % 8), i % 16, (i * 3) % 16, (i * 5 + 1) % 16, (i % 3) != 0,
                i % 4, (i * 7) % 8, (i % 11) == 5);
    begin
      int h = 0, nxt = 0, c;
      bit st_d;
      logic [7:0] lf = 8'hA5;
      for (int cyc = 0; cyc < 400 && nxt < QN; cyc++) begin
        @(negedge clk);
        lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        stall = lf[0] & lf[3];
        older_valid   = (h < QN);
        older_uop     = (h < QN) ? q[h] : '0;
        younger_valid = (h + 1 < QN);
        younger_uop   = (h + 1 < QN) ? q[h + 1] : '0;
        st_d = stall;
        #1 c = int'(consumed);
        @(posedge clk); #1;
        if (!st_d) begin
          if (lane0_valid) begin
            chk(nxt < QN && lane0_uop == q[nxt], "R12 order lane0", int'(lane0_uop), nxt);
            nxt++;
          end
          if (lane1_valid) begin
            chk(nxt < QN && lane1_uop == q[nxt], "R12 order lane1", int'(lane1_uop), nxt);
            nxt++;
          end
        end
        h += c;
      end
      chk(nxt == QN && h == QN, "R12 all delivered once", nxt, QN);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule